// File: doc/BRIEF.md
# Translation Buffer Maintenance Register File

This block is the register window through which privileged software maintains a small address translation buffer. Software selects an entry through an index register. It then reads or writes that entry's data word and tag word through two access registers. A process identifier register supplies the owner tag recorded with each tag write. Writing the search register runs an associative lookup on every entry in one cycle, and the result lands in the index register.

A 3-bit register selector, separate read and write strobes and a 32-bit write bus drive the block. Read data comes back registered, one cycle after the read strobe. Two configuration inputs set how much of the window is usable: a translation level and an access level. Any access that the configuration rejects does nothing and raises a one-cycle error pulse.

Top module: `tlb_regfile`

## Requirements
- R1: After synchronous reset, rd_data, err, the index, PID, zone and both spare registers read 0, and every tag entry is invalid, so a search misses.
- R2: Selector codes: 0 data access, 1 tag access, 2 index, 3 PID, 4 zone, 5 search, 6 and 7 spare. Data and tag accesses address the entry given by the low log2(ENTRIES) bits of the index register. A read presents its value on rd_data one cycle after rd_en. rd_data holds between reads.
- R3: A tag write stores the written word and also records PID bits 7:0 as that entry's owner tag.
- R4: A tag read returns the tag word and loads PID with that entry's owner tag, zero-extended.
- R5: A search write uses bits 31:10 of the written value as the page number. An entry matches when tag bit 6 (valid) is 1, its tag bits 31:10 are equal to the page number, and its owner tag is 0 or equal to PID bits 7:0. The lowest matching entry wins. The index register then reads back that entry number, zero-extended, on the following cycle.
- R6: A search with no matching entry sets index bit 31 and leaves index bits 30:0 unchanged.
- R7: When cfg_mmu_level is below 2 or cfg_tlb_access is 0, every read returns 0 and every write is ignored.
- R8: Writes to PID, zone and search are ignored unless cfg_tlb_access is greater than 1.
- R9: Reads of data, tag, PID and zone return 0 unless cfg_tlb_access bit 0 is 1. Reads of index and spare registers do not need that bit. A search-register read returns 0.
- R10: The index and both spare registers are plain read/write storage whenever the window is open.
- R11: err pulses high for one cycle after each rejected access and is low otherwise. When rd_en and wr_en are both high, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mmu_level | input | 2 | Translation level; 2 or more opens the window |
| cfg_tlb_access | input | 2 | Access level for the register window |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| reg_sel | input | 3 | Register selector |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| err | output | 1 | One-cycle rejected-access pulse |

## Verification
The bench places several valid entries with the same page number, owned by different process identifiers, next to invalid entries. A priority encoder that picked the highest entry, or a compare that ignored the valid bit or the owner tag, would put the wrong number in the index register. Searches that miss start from index values with random upper bits. A design that cleared the index or wrote the miss flag over the low bits would be caught. The bench walks both configuration inputs through their edge values. A gate that compared the access level with the wrong threshold would then let a protected write through, or would let through a read that should return zero. Tag reads followed by PID reads catch a tag read that failed to reload the process identifier.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WORD_W    = 32;
  localparam int TID_W     = 8;
  localparam int EPN_LSB   = 10;
  localparam int VALID_BIT = 6;

  typedef enum logic [2:0] {
    SEL_DATA   = 3'd0,
    SEL_TAG    = 3'd1,
    SEL_INDEX  = 3'd2,
    SEL_PID    = 3'd3,
    SEL_ZONE   = 3'd4,
    SEL_SEARCH = 3'd5,
    SEL_AUX0   = 3'd6,
    SEL_AUX1   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/tlb_access_gate.sv
module tlb_access_gate
  import tlb_pkg::*;
(
  input  logic [1:0] cfg_mmu_level,
  input  logic [1:0] cfg_tlb_access,
  input  logic       rd_en,
  input  logic       wr_en,
  input  reg_sel_e   sel,
  output logic       do_wr,
  output logic       do_rd,
  output logic       rd_block,
  output logic       reject
);
  logic open_w, wr_ok, rd_ok, wr_guarded, rd_guarded;

  always_comb begin
    open_w     = (cfg_mmu_level >= 2'd2) && (cfg_tlb_access != 2'd0);
    wr_guarded = (sel == SEL_PID) || (sel == SEL_ZONE) || (sel == SEL_SEARCH);
    rd_guarded = (sel == SEL_DATA) || (sel == SEL_TAG) || (sel == SEL_PID) || (sel == SEL_ZONE);
    wr_ok      = open_w && (!wr_guarded || (cfg_tlb_access > 2'd1));
    rd_ok      = open_w && (!rd_guarded || cfg_tlb_access[0]);
    do_wr      = wr_en && wr_ok;
    do_rd      = rd_en && !wr_en && rd_ok;
    rd_block   = rd_en && !wr_en && !rd_ok;
    reject     = wr_en ? !wr_ok : (rd_en && !rd_ok);
  end
endmodule

// File: rtl/tlb_data_ram.sv
module tlb_data_ram #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 32,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/tlb_tag_cam.sv
module tlb_tag_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [WORD_W-1:0]         wtag,
  input  logic [TID_W-1:0]          wtid,
  input  logic [AW-1:0]             raddr,
  output logic [WORD_W-1:0]         rtag,
  output logic [TID_W-1:0]          rtid,
  input  logic [WORD_W-1:EPN_LSB]   key_epn,
  input  logic [TID_W-1:0]          key_tid,
  output logic                      hit,
  output logic [AW-1:0]             hit_idx
);
  logic [WORD_W-1:0] tag_q [ENTRIES];
  logic [TID_W-1:0]  tid_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tid_q[i] <= '0;
      end
    end else if (we) begin
      tag_q[waddr] <= wtag;
      tid_q[waddr] <= wtid;
    end
  end

  assign rtag = tag_q[raddr];
  assign rtid = tid_q[raddr];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = tag_q[g][VALID_BIT]
                   && (tag_q[g][WORD_W-1:EPN_LSB] == key_epn)
                   && ((tid_q[g] == '0) || (tid_q[g] == key_tid));
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = AW'(i);
    end
  end
endmodule

// File: rtl/tlb_regfile.sv
module tlb_regfile
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  cfg_mmu_level,
  input  logic [1:0]  cfg_tlb_access,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        err
);
  localparam int AW = $clog2(ENTRIES);

  reg_sel_e          sel;
  logic              do_wr, do_rd, rd_block, reject;
  logic [WORD_W-1:0] idx_q, pid_q, zone_q, rd_hold;
  logic [WORD_W-1:0] aux_q [2];
  logic              from_ram, err_q;
  logic [WORD_W-1:0] ram_q, rtag;
  logic [TID_W-1:0]  rtid;
  logic              srch_hit;
  logic [AW-1:0]     srch_idx, ent;

  assign sel = reg_sel_e'(reg_sel);
  assign ent = idx_q[AW-1:0];

  tlb_access_gate u_gate (
    .cfg_mmu_level (cfg_mmu_level),
    .cfg_tlb_access(cfg_tlb_access),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .sel           (sel),
    .do_wr         (do_wr),
    .do_rd         (do_rd),
    .rd_block      (rd_block),
    .reject        (reject)
  );

  tlb_data_ram #(.ENTRIES(ENTRIES), .WIDTH(WORD_W)) u_data (
    .clk  (clk),
    .we   (do_wr && sel == SEL_DATA),
    .waddr(ent),
    .wdata(wr_data),
    .re   (do_rd && sel == SEL_DATA),
    .raddr(ent),
    .q    (ram_q)
  );

  tlb_tag_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk    (clk),
    .rst    (rst),
    .we     (do_wr && sel == SEL_TAG),
    .waddr  (ent),
    .wtag   (wr_data),
    .wtid   (pid_q[TID_W-1:0]),
    .raddr  (ent),
    .rtag   (rtag),
    .rtid   (rtid),
    .key_epn(wr_data[WORD_W-1:EPN_LSB]),
    .key_tid(pid_q[TID_W-1:0]),
    .hit    (srch_hit),
    .hit_idx(srch_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      pid_q    <= '0;
      zone_q   <= '0;
      aux_q[0] <= '0;
      aux_q[1] <= '0;
      rd_hold  <= '0;
      from_ram <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= reject;
      if (do_wr) begin
        unique case (sel)
          SEL_INDEX:  idx_q  <= wr_data;
          SEL_PID:    pid_q  <= wr_data;
          SEL_ZONE:   zone_q <= wr_data;
          SEL_SEARCH: begin
            if (srch_hit) idx_q <= WORD_W'(srch_idx);
            else          idx_q[WORD_W-1] <= 1'b1;
          end
          SEL_AUX0, SEL_AUX1: aux_q[reg_sel[0]] <= wr_data;
          default: ;
        endcase
      end
      if (do_rd) begin
        from_ram <= (sel == SEL_DATA);
        unique case (sel)
          SEL_TAG: begin
            rd_hold <= rtag;
            pid_q   <= {{(WORD_W-TID_W){1'b0}}, rtid};
          end
          SEL_INDEX:          rd_hold <= idx_q;
          SEL_PID:            rd_hold <= pid_q;
          SEL_ZONE:           rd_hold <= zone_q;
          SEL_AUX0, SEL_AUX1: rd_hold <= aux_q[reg_sel[0]];
          default:            rd_hold <= '0;
        endcase
      end else if (rd_block) begin
        from_ram <= 1'b0;
        rd_hold  <= '0;
      end
    end
  end

  assign rd_data = from_ram ? ram_q : rd_hold;
  assign err     = err_q;
endmodule

// File: rtl/tlb_regfile_chk.sv
module tlb_regfile_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  cfg_mmu_level,
  input logic [1:0]  cfg_tlb_access,
  input logic        rd_en,
  input logic        wr_en,
  input logic [2:0]  reg_sel,
  input logic [31:0] rd_data,
  input logic        err,
  input logic [31:0] idx_q,
  input logic [31:0] pid_q,
  input logic        srch_hit
);
  logic win_open;
  assign win_open = (cfg_mmu_level >= 2'd2) && (cfg_tlb_access != 2'd0);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rd_data == 32'd0 && !err && idx_q == 32'd0 && pid_q == 32'd0));

  // R7
  closed_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !win_open) |=> (rd_data == 32'd0 && err));

  // R7
  closed_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !win_open) |=> ($stable(idx_q) && $stable(pid_q) && err));

  // R8
  pid_wr_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && win_open && cfg_tlb_access <= 2'd1 && reg_sel == 3'd3)
      |=> ($stable(pid_q) && err));

  // R6
  search_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && win_open && cfg_tlb_access > 2'd1 && reg_sel == 3'd5 && !srch_hit)
      |=> (idx_q[31] && idx_q[30:0] == $past(idx_q[30:0])));

  // R11
  idle_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !wr_en) |=> !err);
endmodule

bind tlb_regfile tlb_regfile_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_mmu_level (cfg_mmu_level),
  .cfg_tlb_access(cfg_tlb_access),
  .rd_en         (rd_en),
  .wr_en         (wr_en),
  .reg_sel       (reg_sel),
  .rd_data       (rd_data),
  .err           (err),
  .idx_q         (idx_q),
  .pid_q         (pid_q),
  .srch_hit      (srch_hit)
);

// File: tb/tlb_regfile_bench.sv
`timescale 1ns/1ps
module tlb_regfile_bench;
  localparam int ENTRIES = 16;
  localparam int AW      = $clog2(ENTRIES);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  lvl = 2'd3;
  logic [1:0]  acc = 2'd3;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [31:0] wd = 32'd0;
  logic [31:0] rd_data;
  logic        err;

  int total = 0;
  int bad   = 0;

  // bench model
  logic [31:0] data_m [ENTRIES];
  logic [31:0] tag_m  [ENTRIES];
  logic [7:0]  tid_m  [ENTRIES];
  logic [31:0] idx_m, pid_m, zone_m, rd_m;
  logic [31:0] aux_m [2];

  always #2.5 clk = ~clk;

  tlb_regfile #(.ENTRIES(ENTRIES)) u_tlb_regfile (
    .clk(clk), .rst(rst), .cfg_mmu_level(lvl), .cfg_tlb_access(acc),
    .rd_en(rd_en), .wr_en(wr_en), .reg_sel(sel), .wr_data(wd),
    .rd_data(rd_data), .err(err)
  );

  function automatic int find_entry(input logic [31:0] key);
    int r = -1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (tag_m[i][6] && tag_m[i][31:10] == key[31:10] &&
          (tid_m[i] == 8'd0 || tid_m[i] == pid_m[7:0])) r = i;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic op(input logic [2:0] s, input bit w, input bit r, input logic [31:0] d);
    bit open, guard_w, guard_r, wok, rok, exp_err;
    int ix, h;
    string req;
    open    = (lvl >= 2) && (acc != 0);
    guard_w = (s == 3) || (s == 4) || (s == 5);
    guard_r = (s <= 1) || (s == 3) || (s == 4);
    wok     = open && (!guard_w || acc > 1);
    rok     = open && (!guard_r || acc[0]);
    exp_err = w ? !wok : (r && !rok);
    ix      = int'(idx_m[AW-1:0]);
    if (!open) req = "R7";
    else if (w && !wok) req = "R8";
    else if (!w && r && !rok) req = "R9";
    else case (s)
      3'd0: req = "R2";
      3'd1: req = w ? "R3" : "R4";
      3'd5: req = "R5";
      default: req = "R10";
    endcase
    if (w && wok) begin
      case (s)
        3'd0: data_m[ix] = d;
        3'd1: begin tag_m[ix] = d; tid_m[ix] = pid_m[7:0]; end
        3'd2: idx_m = d;
        3'd3: pid_m = d;
        3'd4: zone_m = d;
        3'd5: begin
          h = find_entry(d);
          if (h >= 0) idx_m = 32'(h);
          else begin idx_m[31] = 1'b1; req = "R6"; end
        end
        default: aux_m[s[0]] = d;
      endcase
    end else if (r && !w) begin
      if (!rok) rd_m = 32'd0;
      else case (s)
        3'd0: rd_m = data_m[ix];
        3'd1: begin rd_m = tag_m[ix]; pid_m = {24'd0, tid_m[ix]}; end
        3'd2: rd_m = idx_m;
        3'd3: rd_m = pid_m;
        3'd4: rd_m = zone_m;
        3'd5: rd_m = 32'd0;
        default: rd_m = aux_m[s[0]];
      endcase
    end
    sel = s; wr_en = w; rd_en = r; wd = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(err == exp_err, exp_err ? req : "R11", {31'd0, err}, {31'd0, exp_err});
    check(rd_data == rd_m, (w && r) ? "R11" : req, rd_data, rd_m);
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d); op(s, 1, 0, d); endtask
  task automatic rdr(input logic [2:0] s); op(s, 0, 1, 32'd0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    idx_m = 0; pid_m = 0; zone_m = 0; rd_m = 0; aux_m[0] = 0; aux_m[1] = 0;
    for (int i = 0; i < ENTRIES; i++) begin tag_m[i] = 0; tid_m[i] = 0; data_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(rd_data == 0 && err == 0, "R1", rd_data, 32'd0);
    rdr(3'd2); rdr(3'd3); rdr(3'd4); rdr(3'd6); rdr(3'd7);
    wr(3'd2, 32'h0000_0005);
    wr(3'd5, 32'h0000_0000);           // R1 invalid tags, R6 miss keeps low bits
    rdr(3'd2);
    check(rd_data == 32'h8000_0005, "R6", rd_data, 32'h8000_0005);
    // fill data and tags
    for (int i = 0; i < ENTRIES; i++) begin
      wr(3'd2, 32'(i));
      wr(3'd0, $urandom());
      wr(3'd1, 32'd0);
    end
    // R5 directed priority and owner tag
    wr(3'd3, 32'd5); wr(3'd2, 32'd3); wr(3'd1, 32'h0001_2040);
    wr(3'd3, 32'd0); wr(3'd2, 32'd7); wr(3'd1, 32'h0001_2040);
    wr(3'd2, 32'd1); wr(3'd1, 32'h0001_2000);  // invalid, same page
    wr(3'd3, 32'd5); wr(3'd5, 32'h0001_23ff); rdr(3'd2);
    check(rd_data == 32'd3, "R5", rd_data, 32'd3);
    wr(3'd3, 32'd9); wr(3'd5, 32'h0001_2000); rdr(3'd2);
    check(rd_data == 32'd7, "R5", rd_data, 32'd7);
    // R4: tag read reloads PID
    wr(3'd2, 32'd3); wr(3'd3, 32'd0); rdr(3'd1); rdr(3'd3);
    check(rd_data == 32'd5, "R4", rd_data, 32'd5);
    // R7 / R8 / R9 gate edges
    lvl = 2'd1; wr(3'd3, 32'hAA); rdr(3'd2); wr(3'd2, 32'd9);
    lvl = 2'd3; acc = 2'd0; rdr(3'd6); wr(3'd6, 32'h77);
    acc = 2'd1; wr(3'd3, 32'h11); wr(3'd4, 32'h22); wr(3'd5, 32'h0001_2000); rdr(3'd0); rdr(3'd3);
    acc = 2'd2; wr(3'd3, 32'h33); rdr(3'd3); rdr(3'd1); rdr(3'd2); rdr(3'd7);
    acc = 2'd3; rdr(3'd3);
    // R11: simultaneous read and write
    op(3'd6, 1, 1, 32'hDEAD_BEEF); rdr(3'd6);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] v;
      int k;
      k = int'($urandom_range(0, 9));
      lvl = (k == 0) ? 2'($urandom_range(0, 1)) : 2'($urandom_range(2, 3));
      acc = (k == 1) ? 2'($urandom_range(0, 2)) : 2'd3;
      v = $urandom();
      case ($urandom_range(0, 7))
        0: v = {19'(0), 3'($urandom_range(0, 7)), 3'(0), 1'($urandom_range(0, 1)), 6'(0)};
        1: v = {22'(0), 10'($urandom_range(0, 3))};
        2: v = {19'(0), 3'($urandom_range(0, 7)), 10'($urandom())};
        default: ;
      endcase
      op(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), v);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule